// File: doc/BRIEF.md
# Interrupt Entry Sequencer with Restartable Divide

This block runs the entry into an interrupt for a small CPU that has a 20-bit program counter and a byte-wide stack. When it accepts a request, it writes four bytes into stack memory, one per clock: the status byte, then the upper nibble, the middle byte and the low byte of a return address. It then loads the program counter from a 16-bit vector with the upper nibble forced to zero, lowers the stack pointer by four and clears the interrupt-enable flag.

A long unsigned divide may be running when the request arrives. In that case the block does not wait for it. In the cycle of acceptance it raises an abort toward the divider, and it stacks the divide's own address rather than the next-instruction address. Because the divide instruction is three bytes long and the program counter already points past it, that address is the current PC minus three, taken modulo 2^20. After the return the divide runs again from its untouched operands. The divider must therefore commit nothing to its register pairs when it is aborted.

The CPU core sets and clears the enable flag through a write strobe. The interrupt source holds its request level until it sees the acknowledge pulse.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where the sequencer is idle, the enable flag is 1 and `irq_req` is 1. In that same cycle `div_abort` is 1 exactly when `div_busy` is 1, and it is 0 in every other cycle.
- R2: The four stack writes go to consecutive descending addresses SP-1, SP-2, SP-3 and SP-4, where SP is the stack pointer at acceptance.
- R3: With no divide in progress, the stacked return address equals `pc_in` at acceptance.
- R4: With a divide in progress, the stacked return address is `pc_in` minus 3, modulo 2^20 (for example 0x00001 gives 0xFFFFE).
- R5: The byte written at SP-1 is the status byte. The byte at SP-2 is {4'h0, RA[19:16]}. The byte at SP-3 is RA[15:8] and the byte at SP-4 is RA[7:0].
- R6: `mem_we` is 1 for exactly the four cycles that follow acceptance. The next cycle carries `irq_ack`=1 and `pc_load`=1 with `pc_out` = {4'h0, vector}.
- R7: From the cycle after `irq_ack`, `sp_out` equals its value at acceptance minus 4.
- R8: The enable flag reads 0 from the cycle after `irq_ack`. Outside entry, `ie_wr` loads it from `ie_wdata` at the next clock.
- R9: Requests are ignored while the enable flag is 0 and while an entry sequence is under way: no stack write and no acknowledge results.
- R10: The status byte, return address and vector are captured at acceptance. Changes to `pc_in`, `psw_in`, `vector_in` or `div_busy` during the sequence do not alter what is stacked or loaded.
- R11: Synchronous active-high reset sets `sp_out` to `SP_INIT`, clears the enable flag and returns the sequencer to idle. Reset also abandons a sequence already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Interrupt request level, held until acknowledged |
| irq_ack | output | 1 | Entry-complete pulse in the load cycle |
| ie_wr | input | 1 | Write strobe for the enable flag |
| ie_wdata | input | 1 | New enable flag value |
| ie_out | output | 1 | Current enable flag |
| pc_in | input | 20 | Current program counter (next-instruction address) |
| psw_in | input | 8 | Current status byte |
| vector_in | input | 16 | Interrupt vector, captured at acceptance |
| div_busy | input | 1 | A multi-cycle divide is running |
| div_abort | output | 1 | Cancel the running divide |
| mem_we | output | 1 | Stack memory byte write enable |
| mem_addr | output | SPW | Stack memory byte address |
| mem_wdata | output | 8 | Stack memory write data |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 20 | New program counter value |
| sp_out | output | SPW | Current stack pointer |

## Verification
The bench goes after the wrap of the minus-three correction at small PCs (0x00001 and 0x00003). A design that subtracted before masking, or that used the wrong width, would stack a truncated or sign-extended address. It changes `pc_in`, `psw_in` and `div_busy` right after acceptance. A block that read them live instead of capturing them would push the wrong frame, and a block that stopped subtracting once the divider dropped busy would stack the wrong return address. It holds the request high across the acknowledge and while the flag is clear, and it resets in the middle of a push. A sequencer that failed to ignore requests would re-enter or write stray bytes, and one that ignored reset mid-sequence would leave the stack pointer moved or the writes running.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  localparam int PCW       = 20;
  localparam int BYTEW     = 8;
  localparam int DIV_BYTES = 3;
  localparam int FRAME_N   = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_LOAD = 2'd2
  } seq_state_e;

  // Return address: a divide in flight is re-run, so back up over its encoding.
  function automatic logic [PCW-1:0] ret_addr(input logic [PCW-1:0] pc,
                                              input logic in_div);
    logic [PCW-1:0] back;
    back = pc - PCW'(DIV_BYTES);
    return in_div ? back : pc;
  endfunction

  // Byte of the interrupt frame written at push slot idx (0 = highest address).
  function automatic logic [BYTEW-1:0] frame_byte(input logic [1:0] idx,
                                                  input logic [BYTEW-1:0] psw,
                                                  input logic [PCW-1:0] ra);
    logic [BYTEW-1:0] b;
    case (idx)
      2'd0:    b = psw;
      2'd1:    b = {4'h0, ra[19:16]};
      2'd2:    b = ra[15:8];
      default: b = ra[7:0];
    endcase
    return b;
  endfunction

  // Byte address for push slot idx below stack pointer sp.
  function automatic logic [15:0] push_addr(input logic [15:0] sp,
                                            input logic [1:0] idx);
    return sp - 16'({14'd0, idx} + 16'd1);
  endfunction

endpackage

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl (
  input  logic irq_req,
  input  logic ie,
  input  logic idle,
  input  logic div_busy,
  output logic accept,
  output logic div_abort
);
  always_comb begin
    accept    = irq_req && ie && idle;
    div_abort = accept && div_busy;
  end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int PUSHES = FRAME_N,
  parameter int IDXW   = $clog2(PUSHES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  output logic            idle,
  output logic            in_push,
  output logic            in_load,
  output logic [IDXW-1:0] push_idx
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(PUSHES - 1);

  seq_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      push_idx <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q  <= ST_PUSH;
            push_idx <= '0;
          end
        end
        ST_PUSH: begin
          if (push_idx == LAST_IDX) state_q <= ST_LOAD;
          else                      push_idx <= push_idx + 1'b1;
        end
        ST_LOAD: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle    = (state_q == ST_IDLE);
    in_push = (state_q == ST_PUSH);
    in_load = (state_q == ST_LOAD);
  end
endmodule

// File: rtl/irq_frame_regs.sv
module irq_frame_regs
  import irq_seq_pkg::*;
#(
  parameter int VECW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             div_busy,
  input  logic [PCW-1:0]   pc_in,
  input  logic [BYTEW-1:0] psw_in,
  input  logic [VECW-1:0]  vector_in,
  input  logic [1:0]       push_idx,
  output logic [BYTEW-1:0] byte_out,
  output logic [PCW-1:0]   new_pc
);
  logic [PCW-1:0]   ra_q;
  logic [BYTEW-1:0] psw_q;
  logic [VECW-1:0]  vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ra_q  <= '0;
      psw_q <= '0;
      vec_q <= '0;
    end else if (accept) begin
      ra_q  <= ret_addr(pc_in, div_busy);
      psw_q <= psw_in;
      vec_q <= vector_in;
    end
  end

  always_comb begin
    byte_out = frame_byte(push_idx, psw_q, ra_q);
    new_pc   = PCW'(vec_q);
  end
endmodule

// File: rtl/irq_sp_ie_regs.sv
module irq_sp_ie_regs #(
  parameter int          SPW     = 16,
  parameter int          PUSHES  = 4,
  parameter logic [15:0] SP_INIT = 16'hFE00
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_load,
  input  logic           ie_wr,
  input  logic           ie_wdata,
  output logic [SPW-1:0] sp_q,
  output logic           ie_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= SPW'(SP_INIT);
      ie_q <= 1'b0;
    end else begin
      if (in_load) sp_q <= sp_q - SPW'(PUSHES);
      if (in_load)    ie_q <= 1'b0;
      else if (ie_wr) ie_q <= ie_wdata;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int          SPW     = 16,
  parameter int          VECW    = 16,
  parameter logic [15:0] SP_INIT = 16'hFE00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             irq_req,
  output logic             irq_ack,
  input  logic             ie_wr,
  input  logic             ie_wdata,
  output logic             ie_out,
  input  logic [PCW-1:0]   pc_in,
  input  logic [BYTEW-1:0] psw_in,
  input  logic [VECW-1:0]  vector_in,
  input  logic             div_busy,
  output logic             div_abort,
  output logic             mem_we,
  output logic [SPW-1:0]   mem_addr,
  output logic [BYTEW-1:0] mem_wdata,
  output logic             pc_load,
  output logic [PCW-1:0]   pc_out,
  output logic [SPW-1:0]   sp_out
);
  localparam int IDXW = $clog2(FRAME_N);

  // Named internal events, observed by the bound checker.
  logic            accept_evt;
  logic            seq_idle;
  logic            seq_push;
  logic            seq_load;
  logic [IDXW-1:0] push_idx;
  logic [SPW-1:0]  sp_q;
  logic            ie_q;

  irq_accept_ctrl u_accept (
    .irq_req  (irq_req),
    .ie       (ie_q),
    .idle     (seq_idle),
    .div_busy (div_busy),
    .accept   (accept_evt),
    .div_abort(div_abort)
  );

  irq_seq_fsm #(.PUSHES(FRAME_N), .IDXW(IDXW)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept_evt),
    .idle    (seq_idle),
    .in_push (seq_push),
    .in_load (seq_load),
    .push_idx(push_idx)
  );

  irq_frame_regs #(.VECW(VECW)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept_evt),
    .div_busy (div_busy),
    .pc_in    (pc_in),
    .psw_in   (psw_in),
    .vector_in(vector_in),
    .push_idx (push_idx),
    .byte_out (mem_wdata),
    .new_pc   (pc_out)
  );

  irq_sp_ie_regs #(.SPW(SPW), .PUSHES(FRAME_N), .SP_INIT(SP_INIT)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .in_load (seq_load),
    .ie_wr   (ie_wr),
    .ie_wdata(ie_wdata),
    .sp_q    (sp_q),
    .ie_q    (ie_q)
  );

  always_comb begin
    mem_we   = seq_push;
    mem_addr = sp_q - SPW'({{(SPW-IDXW){1'b0}}, push_idx} + SPW'(1));
    pc_load  = seq_load;
    irq_ack  = seq_load;
    sp_out   = sp_q;
    ie_out   = ie_q;
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int SPW = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           irq_req,
  input logic           div_busy,
  input logic           div_abort,
  input logic           ie_out,
  input logic           seq_idle,
  input logic           accept_evt,
  input logic           mem_we,
  input logic [SPW-1:0] mem_addr,
  input logic           irq_ack,
  input logic [SPW-1:0] sp_out
);
  assert_abort_needs_accept_R1: assert property (@(posedge clk) disable iff (rst)
    div_abort |-> (div_busy && irq_req && ie_out && seq_idle));

  assert_push_descends_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - SPW'(1)));

  assert_accept_starts_push_R6: assert property (@(posedge clk) disable iff (rst)
    accept_evt |=> mem_we);

  assert_ack_after_push_R6: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(mem_we));

  assert_sp_drop_R7: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (sp_out == $past(sp_out) - SPW'(4)));

  assert_ie_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !ie_out);

  assert_no_accept_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && !ie_out) |=> !mem_we);
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.SPW(SPW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_req   (irq_req),
  .div_busy  (div_busy),
  .div_abort (div_abort),
  .ie_out    (ie_out),
  .seq_idle  (seq_idle),
  .accept_evt(accept_evt),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .irq_ack   (irq_ack),
  .sp_out    (sp_out)
);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  localparam logic [15:0] SP0 = 16'hFE00;

  logic        clk = 1'b0;
  logic        rst;
  logic        irq_req, ie_wr, ie_wdata, div_busy;
  logic [19:0] pc_in;
  logic [7:0]  psw_in;
  logic [15:0] vector_in;
  logic        irq_ack, ie_out, div_abort, mem_we, pc_load;
  logic [15:0] mem_addr, sp_out;
  logic [7:0]  mem_wdata;
  logic [19:0] pc_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] exp_sp;

  always #10 clk = ~clk;

  irq_entry_seq #(.SP_INIT(SP0)) dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_ack(irq_ack),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata), .ie_out(ie_out),
    .pc_in(pc_in), .psw_in(psw_in), .vector_in(vector_in),
    .div_busy(div_busy), .div_abort(div_abort),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .pc_load(pc_load), .pc_out(pc_out), .sp_out(sp_out)
  );

  // {pc, psw, divide busy, vector}
  localparam int NV = 6;
  localparam logic [44:0] VTAB [NV] = '{
    {20'h12345, 8'hA5, 1'b0, 16'h0080},
    {20'h12345, 8'h5A, 1'b1, 16'h0100},
    {20'h00001, 8'h3C, 1'b1, 16'hBEEF},
    {20'hFFFFF, 8'hFF, 1'b0, 16'hFFFF},
    {20'h10000, 8'h00, 1'b1, 16'h1234},
    {20'h00003, 8'h81, 1'b1, 16'h0004}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ie(input logic v);
    @(negedge clk);
    ie_wr = 1'b1; ie_wdata = v;
    @(negedge clk);
    ie_wr = 1'b0;
    chk(ie_out == v, "R8 ie write", 32'(ie_out), 32'(v));
  endtask

  task automatic run_entry(input logic [19:0] pc, input logic [7:0] psw,
                           input logic busy, input logic [15:0] vec);
    logic [19:0] ra;
    logic [23:0] ra24;
    logic [7:0]  eb;
    ra   = busy ? (pc + 20'hFFFFD) : pc;   // minus three, 20-bit wrap
    ra24 = {4'h0, ra};
    set_ie(1'b1);
    pc_in = pc; psw_in = psw; div_busy = busy; vector_in = vec; irq_req = 1'b1;
    #1;
    chk(div_abort == busy, "R1 abort at accept", 32'(div_abort), 32'(busy));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 0) begin
        // R10: upset the live inputs after acceptance
        pc_in = ~pc; psw_in = ~psw; div_busy = 1'b0; vector_in = ~vec;
        chk(div_abort == 1'b0, "R1 abort only at accept", 32'(div_abort), 0);
      end
      eb = (i == 0) ? psw : ra24[(3-i)*8 +: 8];
      chk(mem_we == 1'b1, "R6 write enable", 32'(mem_we), 1);
      chk(mem_addr == exp_sp - 16'(i + 1), "R2 push address", 32'(mem_addr),
          32'(exp_sp - 16'(i + 1)));
      chk(mem_wdata == eb, busy ? "R4 R5 R10 frame byte" : "R3 R5 R10 frame byte",
          32'(mem_wdata), 32'(eb));
    end
    @(negedge clk);
    chk(mem_we == 1'b0, "R6 write stops", 32'(mem_we), 0);
    chk(irq_ack && pc_load, "R6 ack and load", {30'd0, irq_ack, pc_load}, 3);
    chk(pc_out == {4'h0, vec}, "R6 R10 new pc", 32'(pc_out), 32'({4'h0, vec}));
    // request still high: R9 must ignore it now that ie is clear
    @(negedge clk);
    chk(ie_out == 1'b0, "R8 ie cleared", 32'(ie_out), 0);
    chk(sp_out == exp_sp - 16'd4, "R7 sp minus four", 32'(sp_out), 32'(exp_sp - 16'd4));
    chk(mem_we == 1'b0 && irq_ack == 1'b0, "R9 no re-entry", 32'(mem_we), 0);
    irq_req = 1'b0;
    exp_sp = exp_sp - 16'd4;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; irq_req = 1'b0; ie_wr = 1'b0; ie_wdata = 1'b0; div_busy = 1'b0;
    pc_in = '0; psw_in = '0; vector_in = '0;
    exp_sp = SP0;
    repeat (3) @(negedge clk);
    chk(sp_out == SP0, "R11 reset sp", 32'(sp_out), 32'(SP0));
    chk(ie_out == 1'b0, "R11 reset ie", 32'(ie_out), 0);
    chk(mem_we == 1'b0 && irq_ack == 1'b0, "R11 reset idle", 32'(mem_we), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      run_entry(VTAB[v][44:25], VTAB[v][24:17], VTAB[v][16], VTAB[v][15:0]);

    // R9: request while the flag is clear produces nothing
    irq_req = 1'b1; div_busy = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!mem_we && !irq_ack && !div_abort, "R9 disabled ignored",
          {29'd0, mem_we, irq_ack, div_abort}, 0);
    end
    irq_req = 1'b0; div_busy = 1'b0;

    // R8: flag can be cleared again by a write
    set_ie(1'b1);
    set_ie(1'b0);

    // R11: reset in the middle of a push
    set_ie(1'b1);
    pc_in = 20'h0ABCD; psw_in = 8'h11; vector_in = 16'h2222; irq_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1; irq_req = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    chk(sp_out == SP0, "R11 mid reset sp", 32'(sp_out), 32'(SP0));
    chk(ie_out == 1'b0, "R11 mid reset ie", 32'(ie_out), 0);
    @(negedge clk);
    chk(mem_we == 1'b0 && irq_ack == 1'b0, "R11 mid reset idle", 32'(mem_we), 0);
    exp_sp = SP0;

    run_entry(20'h00002, 8'h7E, 1'b1, 16'h0010);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule